// File: doc/BRIEF.md
# SMRAM Access Control Decoder

This block sits on a memory request path and picks one destination for every transaction: DRAM, video memory, a zero sink that returns zeros and drops writes, or the boot flash. Each request carries an address, a write flag and a bit saying whether the requester is currently in system management mode (SMM). The route depends on that bit, the address, and a small set of configuration controls. Because the decision uses the bit carried by each request, two requesters can see different memory maps in the same cycle.

Three protected areas are decoded. The first is the fixed 128 KiB legacy window at 0xA0000..0xBFFFF. The second is a TSEG region that ends at the top of low usable DRAM (TOLUD) and can be resized. The third is the flash region, where writes from requesters outside SMM are dropped so the flash never leaves read mode. Software programs the controls through a two-register write port and can freeze them with a sticky lock bit until reset.

Top module: `smram_access_decoder`

## Requirements
- R1: After reset the open bit and the lock bit are 0, the TSEG size code is 00 and TOLUD holds 0x8000_0000, so a non-SMM read of 0xA0000 goes to video and 0x7FFF_FFF0 goes to DRAM.
- R2: Route codes are 0 = DRAM, 1 = video, 2 = zero sink, 3 = flash. In the window 0xA0000..0xBFFFF an SMM request goes to DRAM and a non-SMM request goes to video. Addresses just outside it go to DRAM.
- R3: While the open bit is 1 and lock is 0, non-SMM requests to the legacy window go to DRAM.
- R4: TSEG covers [TOLUD - size, TOLUD). The size code is 00 = 0, 01 = 1 MiB, 10 = 2 MiB and 11 = 8 MiB. TOLUD keeps only bits 31:20 of the written value.
- R5: A non-SMM request inside TSEG goes to the zero sink. An SMM request inside TSEG goes to DRAM.
- R6: With size code 00 no address is treated as TSEG.
- R7: Register select 0 is the control word: bit 0 is open, bit 1 is lock, and bits 3:2 are the TSEG size. Register select 1 is TOLUD. Once lock is 1, writes to either register have no effect and lock stays 1 until reset.
- R8: While lock is 1 the open bit reads as 0. This holds even when the same write sets both open and lock.
- R9: The flash region is [FLASH_BASE, FLASH_BASE + FLASH_BYTES), which by default is 0xFF00_0000..0xFFFF_FFFF. A non-SMM write there goes to the zero sink. Reads from any requester, and writes from SMM, go to flash.
- R10: The route and the blocked flag follow the request inputs in the same cycle, and they use only the SMM bit of the current request.
- R11: The blocked flag is 1 exactly when a write is dropped, either by the flash filter or by the TSEG zero sink. It is always 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = TOLUD |
| cfg_wdata | input | 32 | Configuration write data |
| req_addr | input | 32 | Transaction address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Requester is in SMM |
| route_o | output | 2 | Selected target (see R2) |
| blocked_o | output | 1 | Write was dropped |

## Verification
Several properties are checked on every clock by the assertions: lock is sticky, the frozen configuration does not move, open is low whenever lock is high, an SMM request never reaches video, a non-SMM request never reaches TSEG or writes flash, and the blocked flag never rises on a read. Other behaviour can only be shown by the bench's scenarios. These are the exact TSEG edges for each size code and TOLUD value, the way a relocated TOLUD moves the region, and the fact that writes attempted after lock change nothing in the routing.

// File: rtl/smram_dec_pkg.sv
package smram_dec_pkg;

    localparam int unsigned MIB_SHIFT = 20;

    typedef enum logic [1:0] {
        RT_DRAM  = 2'd0,
        RT_VIDEO = 2'd1,
        RT_ZERO  = 2'd2,
        RT_FLASH = 2'd3
    } route_e;

    typedef struct packed {
        logic        open_win;
        logic        locked;
        logic [1:0]  tseg_code;
        logic [31:0] top_low;
    } smram_cfg_t;

    typedef struct packed {
        logic in_legacy;
        logic in_tseg;
        logic in_flash;
    } region_hit_t;

    function automatic logic [31:0] tseg_bytes(input logic [1:0] code);
        case (code)
            2'b01:   tseg_bytes = 32'd1 << MIB_SHIFT;
            2'b10:   tseg_bytes = 32'd2 << MIB_SHIFT;
            2'b11:   tseg_bytes = 32'd8 << MIB_SHIFT;
            default: tseg_bytes = 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_dec_pkg::*;
#(
    parameter logic [31:0] TOP_LOW_RESET = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output smram_cfg_t  cfg
);

    localparam int unsigned KEEP_BITS = 32 - MIB_SHIFT;

    smram_cfg_t cfg_q;
    logic       unused_bits;

    assign unused_bits = ^cfg_wdata[MIB_SHIFT-1:4];
    assign cfg = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.open_win  <= 1'b0;
            cfg_q.locked    <= 1'b0;
            cfg_q.tseg_code <= 2'b00;
            cfg_q.top_low   <= TOP_LOW_RESET;
        end else if (cfg_we && !cfg_q.locked) begin
            if (!cfg_sel) begin
                cfg_q.open_win  <= cfg_wdata[0] & ~cfg_wdata[1];
                cfg_q.locked    <= cfg_wdata[1];
                cfg_q.tseg_code <= cfg_wdata[3:2];
            end else begin
                cfg_q.top_low <= {cfg_wdata[31:MIB_SHIFT], {MIB_SHIFT{1'b0}}};
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_q.locked |=> cfg_q.locked); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_q.locked |=> ($stable(cfg_q.tseg_code) && $stable(cfg_q.top_low))); // R7
    AST_OPEN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        cfg_q.locked |-> !cfg_q.open_win); // R8
    AST_TOLUD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        cfg_q.top_low[MIB_SHIFT-1:0] == '0); // R4

    initial begin
        assert (KEEP_BITS > 0); // R4
    end

endmodule

// File: rtl/smram_region_match.sv
module smram_region_match
    import smram_dec_pkg::*;
#(
    parameter logic [31:0] LEGACY_BASE = 32'h000A_0000,
    parameter logic [31:0] LEGACY_SIZE = 32'h0002_0000,
    parameter logic [31:0] FLASH_BASE  = 32'hFF00_0000,
    parameter logic [32:0] FLASH_BYTES = 33'h0100_0000
) (
    input  logic [31:0] addr,
    input  smram_cfg_t  cfg,
    output region_hit_t hit
);

    localparam logic [32:0] LEGACY_END = {1'b0, LEGACY_BASE} + {1'b0, LEGACY_SIZE};
    localparam logic [32:0] FLASH_END  = {1'b0, FLASH_BASE} + FLASH_BYTES;

    logic [32:0] addr_x;
    logic [32:0] tseg_len;
    logic [32:0] tseg_base;
    logic [32:0] top_x;

    always_comb begin
        addr_x   = {1'b0, addr};
        top_x    = {1'b0, cfg.top_low};
        tseg_len = {1'b0, tseg_bytes(cfg.tseg_code)};
        if (tseg_len > top_x) tseg_base = '0;
        else                  tseg_base = top_x - tseg_len;

        hit.in_legacy = (addr_x >= {1'b0, LEGACY_BASE}) && (addr_x < LEGACY_END);
        hit.in_flash  = (addr_x >= {1'b0, FLASH_BASE})  && (addr_x < FLASH_END);
        hit.in_tseg   = (cfg.tseg_code != 2'b00) &&
                        (addr_x >= tseg_base) && (addr_x < top_x);
    end

endmodule

// File: rtl/smram_route_sel.sv
module smram_route_sel
    import smram_dec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  region_hit_t hit,
    input  smram_cfg_t  cfg,
    input  logic        req_write,
    input  logic        req_smm,
    output route_e      route,
    output logic        blocked
);

    logic open_eff;

    assign open_eff = cfg.open_win & ~cfg.locked;

    always_comb begin
        route   = RT_DRAM;
        blocked = 1'b0;
        if (hit.in_flash) begin
            if (req_write && !req_smm) begin
                route   = RT_ZERO;
                blocked = 1'b1;
            end else begin
                route = RT_FLASH;
            end
        end else if (hit.in_tseg) begin
            if (req_smm) begin
                route = RT_DRAM;
            end else begin
                route   = RT_ZERO;
                blocked = req_write;
            end
        end else if (hit.in_legacy) begin
            route = (req_smm || open_eff) ? RT_DRAM : RT_VIDEO;
        end
    end

    AST_SMM_NO_VIDEO: assert property (@(posedge clk) disable iff (rst)
        req_smm |-> route != RT_VIDEO); // R2
    AST_TSEG_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (hit.in_tseg && !hit.in_flash && !req_smm) |-> route == RT_ZERO); // R5
    AST_FLASH_WR_DROP: assert property (@(posedge clk) disable iff (rst)
        (hit.in_flash && req_write && !req_smm) |-> (blocked && route == RT_ZERO)); // R9
    AST_BLOCK_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        blocked |-> (req_write && route == RT_ZERO)); // R11

endmodule

// File: rtl/smram_access_decoder.sv
module smram_access_decoder
    import smram_dec_pkg::*;
#(
    parameter logic [31:0] TOP_LOW_RESET = 32'h8000_0000,
    parameter logic [31:0] FLASH_BASE    = 32'hFF00_0000,
    parameter logic [32:0] FLASH_BYTES   = 33'h0100_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic        req_smm,
    output logic [1:0]  route_o,
    output logic        blocked_o
);

    smram_cfg_t  cfg;
    region_hit_t hit;
    route_e      route;

    smram_cfg_regs #(.TOP_LOW_RESET(TOP_LOW_RESET)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    smram_region_match #(
        .FLASH_BASE  (FLASH_BASE),
        .FLASH_BYTES (FLASH_BYTES)
    ) u_match (
        .addr (req_addr),
        .cfg  (cfg),
        .hit  (hit)
    );

    smram_route_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .cfg       (cfg),
        .req_write (req_write),
        .req_smm   (req_smm),
        .route     (route),
        .blocked   (blocked_o)
    );

    assign route_o = route;

endmodule

// File: tb/smram_access_decoder_bench.sv
module smram_access_decoder_bench;

    typedef struct {
        logic [1:0] route;
        logic       blk;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_smm = 1'b0;
    logic [1:0]  route_o;
    logic        blocked_o;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    localparam logic [1:0] DRAM = 2'd0, VIDEO = 2'd1, ZERO = 2'd2, FLASH = 2'd3;

    always #2 clk = ~clk;

    smram_access_decoder u_smram_access_decoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_addr(req_addr), .req_write(req_write),
        .req_smm(req_smm), .route_o(route_o), .blocked_o(blocked_o)
    );

    task automatic send(input logic [31:0] a, input logic w, input logic s,
                        input logic [1:0] er, input logic eb, input string tag);
        exp_t e;
        @(negedge clk);
        req_addr = a; req_write = w; req_smm = s;
        e.route = er; e.blk = eb; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (route_o !== e.route || blocked_o !== e.blk) begin
                    n_fail++;
                    $display("FAIL %s: route=%0d blocked=%0b expected route=%0d blocked=%0b",
                             e.tag, route_o, blocked_o, e.route, e.blk);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        send(32'h000A_0000, 1'b0, 1'b0, VIDEO, 1'b0, "R1 legacy at reset");
        send(32'h7FFF_FFF0, 1'b0, 1'b0, DRAM,  1'b0, "R1 no TSEG at reset");
        // R2 legacy window
        send(32'h000B_FFFF, 1'b1, 1'b1, DRAM,  1'b0, "R2 smm legacy top");
        send(32'h000B_0000, 1'b1, 1'b0, VIDEO, 1'b0, "R2 non-smm legacy write");
        send(32'h000C_0000, 1'b0, 1'b0, DRAM,  1'b0, "R2 above window");
        send(32'h0009_FFFF, 1'b0, 1'b0, DRAM,  1'b0, "R2 below window");
        // R3 open
        cfg_write(1'b0, 32'h1);
        send(32'h000A_0000, 1'b0, 1'b0, DRAM,  1'b0, "R3 open legacy");
        cfg_write(1'b0, 32'h0);
        send(32'h000A_0000, 1'b0, 1'b0, VIDEO, 1'b0, "R3 closed again");
        // R4 R5 TSEG 1 MiB
        cfg_write(1'b0, 32'h4);
        send(32'h7FF0_0000, 1'b0, 1'b0, ZERO,  1'b0, "R5 tseg1 base read");
        send(32'h7FEF_FFFF, 1'b0, 1'b0, DRAM,  1'b0, "R4 tseg1 below base");
        send(32'h7FFF_FFFF, 1'b1, 1'b0, ZERO,  1'b1, "R11 tseg write dropped");
        send(32'h8000_0000, 1'b0, 1'b0, DRAM,  1'b0, "R4 at TOLUD");
        // R10 alternate requesters, same map state
        send(32'h7FF0_0000, 1'b0, 1'b1, DRAM,  1'b0, "R10 smm tseg");
        send(32'h7FF0_0000, 1'b0, 1'b0, ZERO,  1'b0, "R10 non-smm tseg");
        send(32'h7FF0_0000, 1'b1, 1'b1, DRAM,  1'b0, "R5 smm tseg write");
        // R4 8 MiB and 2 MiB
        cfg_write(1'b0, 32'hC);
        send(32'h7F80_0000, 1'b0, 1'b0, ZERO,  1'b0, "R4 tseg8 base");
        send(32'h7F7F_FFFF, 1'b0, 1'b0, DRAM,  1'b0, "R4 tseg8 below");
        cfg_write(1'b0, 32'h8);
        send(32'h7FE0_0000, 1'b0, 1'b0, ZERO,  1'b0, "R4 tseg2 base");
        send(32'h7FDF_FFFF, 1'b0, 1'b0, DRAM,  1'b0, "R4 tseg2 below");
        // R4 TOLUD move, low bits dropped
        cfg_write(1'b1, 32'h4000_0ABC);
        send(32'h3FE0_0000, 1'b0, 1'b0, ZERO,  1'b0, "R4 moved tseg base");
        send(32'h3FFF_FFFF, 1'b0, 1'b0, ZERO,  1'b0, "R4 moved tseg top");
        send(32'h4000_0000, 1'b0, 1'b0, DRAM,  1'b0, "R4 aligned TOLUD");
        send(32'h7FE0_0000, 1'b0, 1'b0, DRAM,  1'b0, "R4 old tseg freed");
        // R6 size 0
        cfg_write(1'b0, 32'h0);
        send(32'h3FF0_0000, 1'b0, 1'b0, DRAM,  1'b0, "R6 tseg disabled");
        // R9 flash filter
        send(32'hFF00_1000, 1'b1, 1'b0, ZERO,  1'b1, "R9 non-smm flash write");
        send(32'hFF00_1000, 1'b1, 1'b1, FLASH, 1'b0, "R9 smm flash write");
        send(32'hFFFF_FFF0, 1'b0, 1'b0, FLASH, 1'b0, "R9 non-smm flash read");
        send(32'hFEFF_FFFF, 1'b1, 1'b0, DRAM,  1'b0, "R9 below flash");
        send(32'h000A_0000, 1'b0, 1'b0, VIDEO, 1'b0, "R11 read not blocked");
        // R7 R8 lock (TOLUD = 0x4000_0000)
        cfg_write(1'b0, 32'h7);
        send(32'h000A_0000, 1'b0, 1'b0, VIDEO, 1'b0, "R8 open forced low");
        send(32'h3FF0_0000, 1'b0, 1'b0, ZERO,  1'b0, "R7 tseg active at lock");
        cfg_write(1'b0, 32'h0);
        send(32'h3FF0_0000, 1'b0, 1'b0, ZERO,  1'b0, "R7 ctrl write ignored");
        cfg_write(1'b1, 32'h8000_0000);
        send(32'h3FF0_0000, 1'b0, 1'b0, ZERO,  1'b0, "R7 tolud write ignored");
        send(32'h7FF0_0000, 1'b0, 1'b0, DRAM,  1'b0, "R7 tolud unchanged");
        cfg_write(1'b0, 32'h1);
        send(32'h000A_0000, 1'b0, 1'b0, VIDEO, 1'b0, "R8 open stays low");
        // R1 reset clears lock
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        send(32'h3FF0_0000, 1'b0, 1'b0, DRAM,  1'b0, "R1 reset clears tseg");
        cfg_write(1'b0, 32'h1);
        send(32'h000A_0000, 1'b0, 1'b0, DRAM,  1'b0, "R1 lock cleared by reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule